// File: doc/BRIEF.md
# DMA Request Source Selector

This block chooses which event starts a transfer on one DMA channel. A single byte-wide control register holds a 4-bit cause code and a bank bit. The bank bit picks one of two cause tables. In the basic table, the codes select a falling edge of the external interrupt pin, a software strobe, or one of fourteen peripheral event pulses. In the extended table, the codes select the capture/compare base timer, one of eight capture/compare channels, or an event on either edge of the external pin.

The selected source is registered once and leaves the block as a single-cycle `dma_req` pulse. The external pin passes through a synchronizer before its edges are detected. That detector runs all the time, whatever the selection is, so changing the selection never creates a request out of stale pin history. Bit 7 of the register is a write-only strobe. It raises a request only when the same write selects the basic bank with code 0001.

Top module: `dma_trig_select`

## Requirements
- R1: After reset, `rdata` reads 0x00 and `dma_req` is 0.
- R2: A write with `cs`=1 and `we`=1 stores wdata[3:0] as the cause code and wdata[6] as the bank bit. On the next cycle `rdata` returns these fields. Bits 5:4 and bit 7 of `rdata` always read 0.
- R3: A cycle with `cs`=0 or `we`=0 leaves the register unchanged, whatever `wdata` holds.
- R4: In the basic bank (bit 6 = 0), code 0000 selects a falling edge of `ext_pin`. A rising edge gives no request.
- R5: In the basic bank, code c from 0010 to 1111 selects `basic_evt[c-2]`. A pulse on it gives a one-cycle `dma_req` after the next clock edge.
- R6: A write of bit 7 = 1 together with bank 0 and code 0001 gives exactly one `dma_req` pulse, after the second clock edge counted from the write edge. Setting bit 7 with any other bank or code gives no request.
- R7: In the extended bank (bit 6 = 1), the codes select sources as follows. 0000 selects `ext_evt[0]` (base timer). 0001 selects `ext_evt[1]` and 0010 selects `ext_evt[2]`. 0011 selects either edge of `ext_pin`. 0100 to 1001 select `ext_evt[3]` to `ext_evt[8]`.
- R8: In the extended bank, codes 1010 to 1111 never give a request.
- R9: A pulse on any source that is not selected gives no request.
- R10: An edge on `ext_pin` reaches `dma_req` on the third rising clock edge after the pin changes. Two of those edges are synchronizer stages.
- R11: Changing the code or the bank while the pin is steady gives no request, even if the pin changed earlier while it was not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register select |
| we | input | 1 | Write enable, qualified by `cs` |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| basic_evt | input | 14 | Basic-bank peripheral event pulses (timers, serial, converter) |
| ext_evt | input | 9 | Extended-bank event pulses: base timer, then channels 0 to 7 |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| dma_req | output | 1 | Single-cycle DMA request |

## Verification
The bench uses the default parameters: `SYNC_STAGES`=2, `CODE_W`=4 and an idle-high pin reset level. With these values the three-edge pin latency of R10 can be sampled edge by edge. Every one of the fourteen basic codes and nine extended codes can be exercised directly. Holding the pin high through reset keeps the first falling edge unambiguous. The switchover test of R11 can then build pin history under a non-pin selection and show that it does not leak out.

// File: rtl/dma_sel_pkg.sv
package dma_sel_pkg;

   typedef enum logic {
      BANK_BASIC = 1'b0,
      BANK_EXT   = 1'b1
   } bank_e;

   typedef struct packed {
      bank_e      bank;
      logic [3:0] code;
   } sel_t;

   localparam logic [3:0] CODE_PIN_FALL  = 4'd0;
   localparam logic [3:0] CODE_SW_STROBE = 4'd1;
   localparam logic [3:0] CODE_PIN_BOTH  = 4'd3;
   localparam int         BASIC_FIRST    = 2;
   localparam int         EXT_SLOTS      = 9;

   // Extended slot j -> cause code (slot 0 base timer, slots 1..8 channels 0..7)
   function automatic logic [3:0] ext_code(input int j);
      if (j < 3) ext_code = 4'(j);
      else       ext_code = 4'(j + 1);
   endfunction

endpackage

// File: rtl/dma_sel_ctrl_reg.sv
module dma_sel_ctrl_reg
   import dma_sel_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output sel_t              sel,
   output logic              sw_pulse,
   output logic [DATA_W-1:0] rdata
);

   localparam int BANK_BIT = 6;
   localparam int SW_BIT   = 7;

   if (DATA_W != 8) begin : g_bad_width
      $error("dma_sel_ctrl_reg: DATA_W must be 8");
   end

   logic wr_en;
   logic sw_hit;

   assign wr_en  = cs && we;
   assign sw_hit = wr_en && wdata[SW_BIT] && !wdata[BANK_BIT]
                   && (wdata[3:0] == CODE_SW_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel      <= '{bank: BANK_BASIC, code: 4'd0};
         sw_pulse <= 1'b0;
      end else begin
         sw_pulse <= sw_hit;
         if (wr_en) begin
            sel.bank <= bank_e'(wdata[BANK_BIT]);
            sel.code <= wdata[3:0];
         end
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[3:0]      = sel.code;
      rdata[BANK_BIT] = sel.bank;
   end

endmodule

// File: rtl/dma_sel_pin_edge.sv
module dma_sel_pin_edge #(
   parameter int   SYNC_STAGES = 2,
   parameter logic RST_LVL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall_evt,
   output logic any_evt
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dma_sel_pin_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   now_lvl;

   assign now_lvl = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{RST_LVL}};
         last_q <= RST_LVL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         last_q <= now_lvl;
      end
   end

   assign fall_evt = last_q && !now_lvl;
   assign any_evt  = last_q ^ now_lvl;

endmodule

// File: rtl/dma_sel_mux.sv
module dma_sel_mux
   import dma_sel_pkg::*;
#(
   parameter int CODE_W = 4,
   localparam int N_BASIC = (1 << CODE_W) - BASIC_FIRST
) (
   input  sel_t               sel,
   input  logic [N_BASIC-1:0] basic_evt,
   input  logic [EXT_SLOTS-1:0] ext_evt,
   input  logic               pin_fall,
   input  logic               pin_any,
   input  logic               sw_pulse,
   output logic               src_evt
);

   logic [N_BASIC-1:0]   basic_hit;
   logic [EXT_SLOTS-1:0] ext_hit;
   logic                 basic_src;
   logic                 ext_src;

   for (genvar g = 0; g < N_BASIC; g++) begin : g_basic
      assign basic_hit[g] = basic_evt[g] && (sel.code == CODE_W'(g + BASIC_FIRST));
   end

   for (genvar j = 0; j < EXT_SLOTS; j++) begin : g_ext
      assign ext_hit[j] = ext_evt[j] && (sel.code == ext_code(j));
   end

   always_comb begin
      basic_src = |basic_hit;
      if (sel.code == CODE_PIN_FALL)  basic_src = pin_fall;
      if (sel.code == CODE_SW_STROBE) basic_src = sw_pulse;
      ext_src = |ext_hit;
      if (sel.code == CODE_PIN_BOTH)  ext_src = pin_any;
      src_evt = (sel.bank == BANK_EXT) ? ext_src : basic_src;
   end

endmodule

// File: rtl/dma_trig_select.sv
module dma_trig_select
   import dma_sel_pkg::*;
#(
   parameter int   CODE_W      = 4,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_RST_LVL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs,
   input  logic                      we,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   input  logic [(1<<CODE_W)-3:0]    basic_evt,
   input  logic [8:0]                ext_evt,
   input  logic                      ext_pin,
   output logic                      dma_req
);

   if (CODE_W != 4) begin : g_bad_code
      $error("dma_trig_select: CODE_W must be 4 to fit the register layout");
   end

   sel_t sel;
   logic sw_pulse;
   logic pin_fall;
   logic pin_any;
   logic src_evt;

   dma_sel_ctrl_reg #(.DATA_W(8)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .we       (we),
      .wdata    (wdata),
      .sel      (sel),
      .sw_pulse (sw_pulse),
      .rdata    (rdata)
   );

   dma_sel_pin_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(PIN_RST_LVL)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_evt (pin_fall),
      .any_evt  (pin_any)
   );

   dma_sel_mux #(.CODE_W(CODE_W)) u_mux (
      .sel       (sel),
      .basic_evt (basic_evt),
      .ext_evt   (ext_evt),
      .pin_fall  (pin_fall),
      .pin_any   (pin_any),
      .sw_pulse  (sw_pulse),
      .src_evt   (src_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_req <= 1'b0;
      else        dma_req <= src_evt;
   end

endmodule

// File: rtl/dma_trig_select_chk.sv
module dma_trig_select_chk #(
   parameter int CODE_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cs,
   input logic                   we,
   input logic [7:0]             wdata,
   input logic [7:0]             rdata,
   input logic [(1<<CODE_W)-3:0] basic_evt,
   input logic [8:0]             ext_evt,
   input logic                   dma_req
);

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[7] == 1'b0 && rdata[5:4] == 2'b00); // R2

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we) |=> rdata == ($past(wdata) & 8'h4F)); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && we) |=> $stable(rdata)); // R3

   AST_SW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && wdata[7] && !wdata[6] && wdata[3:0] == 4'd1) |=> ##1 dma_req); // R6

   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[6] && rdata[3:0] >= 4'd10) |=> !dma_req); // R8

   AST_FIRST_BASIC: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata == 8'h02 && basic_evt[0]) |=> dma_req); // R5

   AST_EXT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata == 8'h40 && ext_evt[0]) |=> dma_req); // R7

endmodule

bind dma_trig_select dma_trig_select_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .we        (we),
   .wdata     (wdata),
   .rdata     (rdata),
   .basic_evt (basic_evt),
   .ext_evt   (ext_evt),
   .dma_req   (dma_req)
);

// File: tb/dma_trig_select_test.sv
module dma_trig_select_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic [13:0] basic_evt = '0;
   logic [8:0]  ext_evt = '0;
   logic        ext_pin = 1'b1;
   logic        dma_req;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dma_trig_select uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (cs),
      .we        (we),
      .wdata     (wdata),
      .rdata     (rdata),
      .basic_evt (basic_evt),
      .ext_evt   (ext_evt),
      .ext_pin   (ext_pin),
      .dma_req   (dma_req)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic c = 1'b1, input logic w = 1'b1);
      @(negedge clk);
      cs = c; we = w; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0; wdata = 8'h00;
   endtask

   // pulse one source for a cycle, then check dma_req one edge later and after
   task automatic pulse_chk(input logic is_ext, input int idx, input logic exp, input string req);
      @(negedge clk);
      if (is_ext) ext_evt[idx] = 1'b1; else basic_evt[idx] = 1'b1;
      @(negedge clk);
      ext_evt = '0; basic_evt = '0;
      chk(dma_req == exp, req, dma_req, exp);
      @(negedge clk);
      chk(dma_req == 1'b0, req, dma_req, 0);
   endtask

   // move the pin and follow dma_req edge by edge
   task automatic pin_chk(input logic lvl, input logic exp, input string req);
      @(negedge clk);
      ext_pin = lvl;
      @(negedge clk);
      @(negedge clk);
      chk(dma_req == 1'b0, req, dma_req, 0);
      @(negedge clk);
      chk(dma_req == exp, req, dma_req, exp);
      @(negedge clk);
      chk(dma_req == 1'b0, req, dma_req, 0);
   endtask

   task automatic t_reset;
      chk(rdata == 8'h00, "R1", rdata, 8'h00);
      chk(dma_req == 1'b0, "R1", dma_req, 0);
   endtask

   task automatic t_regs;
      wr(8'hFF);
      chk(rdata == 8'h4F, "R2", rdata, 8'h4F);
      wr(8'h35);
      chk(rdata == 8'h05, "R2", rdata, 8'h05);
      wr(8'h4A, 1'b0, 1'b1);
      chk(rdata == 8'h05, "R3", rdata, 8'h05);
      wr(8'h4A, 1'b1, 1'b0);
      chk(rdata == 8'h05, "R3", rdata, 8'h05);
   endtask

   task automatic t_basic;
      for (int c = 2; c < 16; c++) begin
         wr(8'(c));
         pulse_chk(1'b0, c - 2, 1'b1, "R5");
         pulse_chk(1'b0, (c - 1) % 14, 1'b0, "R9");
         pulse_chk(1'b1, c % 9, 1'b0, "R9");
      end
   endtask

   task automatic t_soft;
      @(negedge clk);
      cs = 1'b1; we = 1'b1; wdata = 8'h81;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
      chk(dma_req == 1'b0, "R6", dma_req, 0);
      chk(rdata == 8'h01, "R6", rdata, 8'h01);
      @(negedge clk);
      chk(dma_req == 1'b1, "R6", dma_req, 1);
      @(negedge clk);
      chk(dma_req == 1'b0, "R6", dma_req, 0);
      foreach (wdata[i]) ;
      wr(8'hC1);
      @(negedge clk);
      chk(dma_req == 1'b0, "R6", dma_req, 0);
      wr(8'h82);
      @(negedge clk);
      chk(dma_req == 1'b0, "R6", dma_req, 0);
   endtask

   task automatic t_pin_basic;
      wr(8'h00);
      pin_chk(1'b0, 1'b1, "R4 R10");
      pin_chk(1'b1, 1'b0, "R4");
   endtask

   task automatic t_ext;
      for (int j = 0; j < 9; j++) begin
         int code = (j < 3) ? j : j + 1;
         wr(8'h40 | 8'(code));
         pulse_chk(1'b1, j, 1'b1, "R7");
         pulse_chk(1'b1, (j + 1) % 9, 1'b0, "R9");
         pulse_chk(1'b0, j, 1'b0, "R9");
      end
      wr(8'h43);
      pin_chk(1'b0, 1'b1, "R7 R10");
      pin_chk(1'b1, 1'b1, "R7 R10");
      for (int c = 10; c < 16; c++) begin
         wr(8'h40 | 8'(c));
         @(negedge clk);
         ext_evt = '1; basic_evt = '1; ext_pin = ~ext_pin;
         @(negedge clk);
         ext_evt = '0; basic_evt = '0;
         for (int k = 0; k < 4; k++) begin
            chk(dma_req == 1'b0, "R8", dma_req, 0);
            @(negedge clk);
         end
      end
      ext_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_switch;
      wr(8'h05);
      @(negedge clk);
      ext_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk(dma_req == 1'b0, "R11", dma_req, 0);
      wr(8'h00);
      for (int k = 0; k < 3; k++) begin
         chk(dma_req == 1'b0, "R11", dma_req, 0);
         @(negedge clk);
      end
      wr(8'h43);
      for (int k = 0; k < 3; k++) begin
         chk(dma_req == 1'b0, "R11", dma_req, 0);
         @(negedge clk);
      end
      wr(8'h00);
      chk(dma_req == 1'b0, "R11", dma_req, 0);
      pin_chk(1'b1, 1'b0, "R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_basic();
      t_soft();
      t_pin_basic();
      t_ext();
      t_switch();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule